// File: doc/BRIEF.md
# Dual-halfword dot-product accumulator

This unit multiplies the two signed 16-bit halves of one 32-bit source word by the two halves of a second source word. It adds the two products to one of four 64-bit accumulators, or subtracts them from it. A 5-bit operation code selects the variant. The halves can be paired low-with-low and high-with-high (straight), or low-with-high and high-with-low (crossed). The products can be plain integers or Q15 fractions, which are doubled. The final accumulator value can optionally be clamped to the signed 32-bit range.

Each accumulator has its own sticky overflow flag. A fractional product of two most-negative halves sets that flag, and so does a clamp. A register-file style port reads any accumulator as hi and lo words, and a second port loads one. At most one operation is accepted per cycle, and its result is visible one cycle later.

Top module: `dot_mac_unit`

## Requirements
- R1: After reset, all four accumulators read 0 and all overflow flags are 0.
- R2: Code 00000 (straight add) adds src_a.lo*src_b.lo + src_a.hi*src_b.hi (signed 16x16) to accumulator op_acc_i. The new value reads back on the cycle after the operation, and back-to-back operations accumulate.
- R3: Code 00001 (straight subtract) subtracts the same two products from the selected accumulator.
- R4: Codes 01000 (crossed add) and 01001 (crossed subtract) use src_a.lo*src_b.hi + src_a.hi*src_b.lo.
- R5: Codes 11000 (Q15 crossed add) and 11001 (Q15 crossed subtract) use crossed pairing with each product shifted left by one bit.
- R6: In the Q15 codes, a lane whose two halves are both 0x8000 contributes 0x7FFFFFFF and sets the overflow flag of the target accumulator.
- R7: Codes 11010 (Q15 crossed add, clamped) and 11011 (Q15 crossed subtract, clamped) clamp the whole 64-bit result. A result above 0x7FFFFFFF becomes 0x7FFFFFFF, and one below -2^31 becomes -2^31 (hi word all ones, lo word 0x80000000). A clamp sets the flag. An in-range result is unchanged and sets no flag.
- R8: ovf_o bit n is the flag of accumulator n. It stays set until ovf_clr_i is high on a clock edge. If a flag is set by an operation in the same cycle as a clear, the flag ends up set.
- R9: Only the selected accumulator changes. The codes without clamping wrap modulo 2^64 and never set a flag by overflowing.
- R10: rd_hi_o/rd_lo_o show the upper and lower 32 bits of accumulator rd_acc_i combinationally, without waiting for a clock edge.
- R11: wr_en_i loads {wr_hi_i, wr_lo_i} into accumulator wr_acc_i on the next edge. If an operation targets the same accumulator in the same cycle, the write wins and the operation's result and flag are both discarded. Operations on other accumulators proceed.
- R12: An operation with op_valid_i low, or with any code outside the eight listed, changes no accumulator and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation request this cycle |
| op_code_i | input | 5 | Operation variant code |
| op_acc_i | input | 2 | Target accumulator of the operation |
| src_a_i | input | 32 | First source, two signed halves |
| src_b_i | input | 32 | Second source, two signed halves |
| wr_en_i | input | 1 | Load an accumulator from the write port |
| wr_acc_i | input | 2 | Accumulator to load |
| wr_hi_i | input | 32 | Upper word to load |
| wr_lo_i | input | 32 | Lower word to load |
| rd_acc_i | input | 2 | Accumulator shown on the read port |
| rd_hi_o | output | 32 | Upper word of the read accumulator |
| rd_lo_o | output | 32 | Lower word of the read accumulator |
| ovf_clr_i | input | 1 | Clear all overflow flags |
| ovf_o | output | 4 | Sticky overflow flag per accumulator |

## Verification
Two pairs of functions can meet in one cycle. The first is a port load and an operation. The bench aims both at one accumulator, using Q15 most-negative inputs that would otherwise set a flag. The loaded value must survive, with no flag. It then aims them at different accumulators and expects both updates. The second pair is a flag clear and a new overflow event. The bench raises ovf_clr_i while an operation trips the flag of another accumulator. The older flag must drop and the new one must remain.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int unsigned OPC_W = 5;

  // bit0 subtract, bit1 clamp, bit3 crossed, bit4 q15
  localparam logic [OPC_W-1:0] OPC_MAC_STR  = 5'b00000;
  localparam logic [OPC_W-1:0] OPC_MSU_STR  = 5'b00001;
  localparam logic [OPC_W-1:0] OPC_MAC_X    = 5'b01000;
  localparam logic [OPC_W-1:0] OPC_MSU_X    = 5'b01001;
  localparam logic [OPC_W-1:0] OPC_QMAC_X   = 5'b11000;
  localparam logic [OPC_W-1:0] OPC_QMSU_X   = 5'b11001;
  localparam logic [OPC_W-1:0] OPC_QMAC_XS  = 5'b11010;
  localparam logic [OPC_W-1:0] OPC_QMSU_XS  = 5'b11011;

  typedef struct packed {
    logic legal;
    logic subtract;
    logic crossed;
    logic q15;
    logic clamp;
  } op_ctrl_t;
endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
  import dmac_pkg::*;
(
  input  logic [OPC_W-1:0] op_i,
  output op_ctrl_t         ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (op_i)
      OPC_MAC_STR, OPC_MSU_STR, OPC_MAC_X, OPC_MSU_X,
      OPC_QMAC_X, OPC_QMSU_X, OPC_QMAC_XS, OPC_QMSU_XS: begin
        ctrl_o.legal    = 1'b1;
        ctrl_o.subtract = op_i[0];
        ctrl_o.clamp    = op_i[1];
        ctrl_o.crossed  = op_i[3];
        ctrl_o.q15      = op_i[4];
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/dmac_lane_mul.sv
module dmac_lane_mul #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic [WORD_W-1:0]      a_i,
  input  logic [WORD_W-1:0]      b_i,
  input  logic                   crossed_i,
  input  logic                   q15_i,
  output logic [1:0][WORD_W-1:0] term_o,
  output logic [1:0]             special_o
);
  localparam logic [HALF_W-1:0] HALF_MIN = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] WORD_MAX = {1'b0, {(WORD_W-1){1'b1}}};

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [HALF_W-1:0]        x, y;
    logic signed [WORD_W-1:0] xe, ye, prod;

    assign x    = a_i[l*HALF_W +: HALF_W];
    assign y    = crossed_i ? b_i[(1-l)*HALF_W +: HALF_W] : b_i[l*HALF_W +: HALF_W];
    assign xe   = {{HALF_W{x[HALF_W-1]}}, x};
    assign ye   = {{HALF_W{y[HALF_W-1]}}, y};
    assign prod = xe * ye;

    assign special_o[l] = q15_i && (x == HALF_MIN) && (y == HALF_MIN);

    always_comb begin
      if (special_o[l])  term_o[l] = WORD_MAX;
      else if (q15_i)    term_o[l] = {prod[WORD_W-2:0], 1'b0};
      else               term_o[l] = prod;
    end
  end
endmodule

// File: rtl/dmac_accum_core.sv
module dmac_accum_core #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned ACC_W = 2 * WORD_W
) (
  input  logic [ACC_W-1:0]       acc_i,
  input  logic [1:0][WORD_W-1:0] term_i,
  input  logic [1:0]             special_i,
  input  logic                   subtract_i,
  input  logic                   clamp_i,
  output logic [ACC_W-1:0]       acc_o,
  output logic                   ovf_o
);
  localparam logic [ACC_W-1:0] POS_LIM = {{(WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = {{(WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};

  logic [1:0][ACC_W-1:0] ext;
  logic [ACC_W-1:0]      pair_sum, raw;
  logic                  above, below;

  for (genvar l = 0; l < 2; l++) begin : g_ext
    assign ext[l] = {{WORD_W{term_i[l][WORD_W-1]}}, term_i[l]};
  end

  assign pair_sum = ext[0] + ext[1];
  assign raw      = subtract_i ? (acc_i - pair_sum) : (acc_i + pair_sum);
  assign above    = $signed(raw) > $signed(POS_LIM);
  assign below    = $signed(raw) < $signed(NEG_LIM);

  always_comb begin
    if (clamp_i && above)      acc_o = POS_LIM;
    else if (clamp_i && below) acc_o = NEG_LIM;
    else                       acc_o = raw;
  end

  assign ovf_o = (|special_i) | (clamp_i & (above | below));
endmodule

// File: rtl/dmac_acc_bank.sv
module dmac_acc_bank #(
  parameter int unsigned N_ACC = 4,
  parameter int unsigned ACC_W = 64,
  localparam int unsigned SEL_W = $clog2(N_ACC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_we_i,
  input  logic [SEL_W-1:0] op_sel_i,
  input  logic [ACC_W-1:0] op_val_i,
  input  logic             op_ovf_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [ACC_W-1:0] wr_val_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [ACC_W-1:0] rd_val_o,
  output logic [ACC_W-1:0] op_acc_o,
  output logic [N_ACC-1:0] ovf_o
);
  logic [ACC_W-1:0] acc_q [N_ACC];
  logic [N_ACC-1:0] ovf_q, set_ovf;

  for (genvar g = 0; g < N_ACC; g++) begin : g_acc
    logic             wr_hit, op_hit, ovf_r;
    logic [ACC_W-1:0] acc_r;

    assign wr_hit     = wr_en_i && (wr_sel_i == SEL_W'(g));
    assign op_hit     = op_we_i && (op_sel_i == SEL_W'(g)) && !wr_hit;
    assign set_ovf[g] = op_hit && op_ovf_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_r <= '0;
        ovf_r <= 1'b0;
      end else begin
        if (wr_hit)      acc_r <= wr_val_i;
        else if (op_hit) acc_r <= op_val_i;
        ovf_r <= set_ovf[g] | (ovf_r & ~clr_i);
      end
    end

    assign acc_q[g] = acc_r;
    assign ovf_q[g] = ovf_r;

    p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_q[g] && !clr_i) |=> ovf_q[g]);
    p_flag_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_ovf[g]) |=> !ovf_q[g]);
  end

  assign rd_val_o = acc_q[rd_sel_i];
  assign op_acc_o = acc_q[op_sel_i];
  assign ovf_o    = ovf_q;

  p_write_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> acc_q[$past(wr_sel_i)] == $past(wr_val_i));
  p_op_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_we_i && !(wr_en_i && wr_sel_i == op_sel_i)) |=> acc_q[$past(op_sel_i)] == $past(op_val_i));
endmodule

// File: rtl/dot_mac_unit.sv
module dot_mac_unit
  import dmac_pkg::*;
#(
  parameter int unsigned ACC_CNT = 4,
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned SEL_W  = $clog2(ACC_CNT),
  localparam int unsigned ACC_W  = 2 * WORD_W,
  localparam int unsigned HALF_W = WORD_W / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [OPC_W-1:0]   op_code_i,
  input  logic [SEL_W-1:0]   op_acc_i,
  input  logic [WORD_W-1:0]  src_a_i,
  input  logic [WORD_W-1:0]  src_b_i,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_acc_i,
  input  logic [WORD_W-1:0]  wr_hi_i,
  input  logic [WORD_W-1:0]  wr_lo_i,
  input  logic [SEL_W-1:0]   rd_acc_i,
  output logic [WORD_W-1:0]  rd_hi_o,
  output logic [WORD_W-1:0]  rd_lo_o,
  input  logic               ovf_clr_i,
  output logic [ACC_CNT-1:0] ovf_o
);
  localparam logic [HALF_W-1:0] HALF_MIN = {1'b1, {(HALF_W-1){1'b0}}};

  op_ctrl_t              ctrl;
  logic                  op_fire;
  logic [1:0][WORD_W-1:0] term;
  logic [1:0]            special;
  logic [ACC_W-1:0]      acc_cur, acc_next, rd_val;
  logic                  ovf_hit;

  dmac_decode i_decode (
    .op_i   (op_code_i),
    .ctrl_o (ctrl)
  );

  assign op_fire = op_valid_i && ctrl.legal;

  dmac_lane_mul #(.HALF_W(HALF_W)) i_lanes (
    .a_i       (src_a_i),
    .b_i       (src_b_i),
    .crossed_i (ctrl.crossed),
    .q15_i     (ctrl.q15),
    .term_o    (term),
    .special_o (special)
  );

  dmac_accum_core #(.WORD_W(WORD_W)) i_core (
    .acc_i      (acc_cur),
    .term_i     (term),
    .special_i  (special),
    .subtract_i (ctrl.subtract),
    .clamp_i    (ctrl.clamp),
    .acc_o      (acc_next),
    .ovf_o      (ovf_hit)
  );

  dmac_acc_bank #(.N_ACC(ACC_CNT), .ACC_W(ACC_W)) i_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_we_i  (op_fire),
    .op_sel_i (op_acc_i),
    .op_val_i (acc_next),
    .op_ovf_i (ovf_hit),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_acc_i),
    .wr_val_i ({wr_hi_i, wr_lo_i}),
    .clr_i    (ovf_clr_i),
    .rd_sel_i (rd_acc_i),
    .rd_val_o (rd_val),
    .op_acc_o (acc_cur),
    .ovf_o    (ovf_o)
  );

  assign rd_hi_o = rd_val[ACC_W-1:WORD_W];
  assign rd_lo_o = rd_val[WORD_W-1:0];

  p_clamp_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_fire && ctrl.clamp) |->
      (acc_next[ACC_W-1:WORD_W-1] == '0) || (acc_next[ACC_W-1:WORD_W-1] == '1));
  p_q15_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_fire && ctrl.q15 && src_a_i[HALF_W-1:0] == HALF_MIN &&
     src_b_i[WORD_W-1:HALF_W] == HALF_MIN && !(wr_en_i && wr_acc_i == op_acc_i))
      |=> ovf_o[$past(op_acc_i)]);
  p_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !ctrl.legal && !wr_en_i && !ovf_clr_i) |=> $stable(ovf_o));
endmodule

// File: tb/test_dot_mac_unit.sv
module test_dot_mac_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;
  localparam int NVEC       = 20;

  typedef struct packed {
    logic [1:0]  sel;
    logic [4:0]  code;
    logic [31:0] pre_hi;
    logic [31:0] pre_lo;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp_hi;
    logic [31:0] exp_lo;
    logic        exp_ovf;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 5'b00000, 32'h0, 32'h0,        32'h0003_0002, 32'h0005_0004, 32'h0,        32'h17,       1'b0},
    '{2'd1, 5'b00001, 32'h0, 32'h64,       32'h0003_0002, 32'h0005_0004, 32'h0,        32'h4D,       1'b0},
    '{2'd2, 5'b00001, 32'h0, 32'h0,        32'h0001_0001, 32'h0001_0001, 32'hFFFFFFFF, 32'hFFFFFFFE, 1'b0},
    '{2'd3, 5'b00000, 32'h0, 32'h0,        32'hFFFF_FFFE, 32'h0003_0004, 32'hFFFFFFFF, 32'hFFFFFFF5, 1'b0},
    '{2'd0, 5'b01000, 32'h0, 32'h0,        32'h0003_0002, 32'h0005_0004, 32'h0,        32'h16,       1'b0},
    '{2'd1, 5'b01001, 32'h0, 32'h100,      32'h0003_0002, 32'h0005_0004, 32'h0,        32'hEA,       1'b0},
    '{2'd2, 5'b11000, 32'h0, 32'h0,        32'h0003_0002, 32'h0005_0004, 32'h0,        32'h2C,       1'b0},
    '{2'd3, 5'b11001, 32'h0, 32'h64,       32'h0003_0002, 32'h0005_0004, 32'h0,        32'h38,       1'b0},
    '{2'd0, 5'b11000, 32'h0, 32'h0,        32'h0000_8000, 32'h8000_0000, 32'h0,        32'h7FFFFFFF, 1'b1},
    '{2'd1, 5'b11000, 32'h0, 32'h0,        32'h8000_8000, 32'h8000_8000, 32'h0,        32'hFFFFFFFE, 1'b1},
    '{2'd2, 5'b11001, 32'h0, 32'h0,        32'h0000_8000, 32'h8000_0000, 32'hFFFFFFFF, 32'h80000001, 1'b1},
    '{2'd3, 5'b11010, 32'h0, 32'h7FFFFFF0, 32'h0000_0004, 32'h0004_0000, 32'h0,        32'h7FFFFFFF, 1'b1},
    '{2'd0, 5'b11011, 32'hFFFFFFFF, 32'h80000010, 32'h0000_0004, 32'h0004_0000, 32'hFFFFFFFF, 32'h80000000, 1'b1},
    '{2'd1, 5'b11010, 32'h0, 32'h0,        32'h0000_0003, 32'h0002_0000, 32'h0,        32'hC,        1'b0},
    '{2'd2, 5'b11010, 32'h1, 32'h0,        32'h0,         32'h0,         32'h0,        32'h7FFFFFFF, 1'b1},
    '{2'd3, 5'b11011, 32'h80000000, 32'h0, 32'h0,         32'h0,         32'hFFFFFFFF, 32'h80000000, 1'b1},
    '{2'd0, 5'b00000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h0000_0001, 32'h0000_0001, 32'h80000000, 32'h0, 1'b0},
    '{2'd1, 5'b11000, 32'h0, 32'h0,        32'h0000_8000, 32'h0001_0000, 32'hFFFFFFFF, 32'hFFFF0000, 1'b0},
    '{2'd2, 5'b00000, 32'h0, 32'h0,        32'h0000_8000, 32'h0000_8000, 32'h0,        32'h40000000, 1'b0},
    '{2'd3, 5'b00000, 32'h0, 32'h0,        32'h8000_8000, 32'h8000_8000, 32'h0,        32'h80000000, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [4:0]  op_code_i = '0;
  logic [1:0]  op_acc_i = '0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_acc_i = '0;
  logic [31:0] wr_hi_i = '0;
  logic [31:0] wr_lo_i = '0;
  logic [1:0]  rd_acc_i = '0;
  logic [31:0] rd_hi_o, rd_lo_o;
  logic        ovf_clr_i = 1'b0;
  logic [3:0]  ovf_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dot_mac_unit i_dot_mac_unit (
    .clk_i, .rst_ni, .op_valid_i, .op_code_i, .op_acc_i, .src_a_i, .src_b_i,
    .wr_en_i, .wr_acc_i, .wr_hi_i, .wr_lo_i, .rd_acc_i, .rd_hi_o, .rd_lo_o,
    .ovf_clr_i, .ovf_o
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WDOG_CYC) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < %0d", cyc, WDOG_CYC);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] sel, input logic [31:0] eh, input logic [31:0] el);
    rd_acc_i = sel;
    #1;
    chk(tag, {rd_hi_o, rd_lo_o}, {eh, el});
  endtask

  task automatic flag_chk(input string tag, input logic [3:0] exp);
    #1;
    chk(tag, 64'(ovf_o), 64'(exp));
  endtask

  task automatic load(input logic [1:0] sel, input logic [31:0] hi, input logic [31:0] lo);
    wr_en_i = 1'b1; wr_acc_i = sel; wr_hi_i = hi; wr_lo_i = lo;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic issue(input logic vld, input logic [1:0] sel, input logic [4:0] code,
                       input logic [31:0] a, input logic [31:0] b);
    op_valid_i = vld; op_acc_i = sel; op_code_i = code; src_a_i = a; src_b_i = b;
    @(negedge clk_i);
    op_valid_i = 1'b0;
  endtask

  task automatic clear_flags();
    ovf_clr_i = 1'b1;
    @(negedge clk_i);
    ovf_clr_i = 1'b0;
  endtask

  function automatic string req_of(input logic [4:0] code, input logic ovf);
    case (code)
      5'b00000: return "R2";
      5'b00001: return "R3";
      5'b01000, 5'b01001: return "R4";
      5'b11000, 5'b11001: return ovf ? "R6" : "R5";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset state
    for (int s = 0; s < 4; s++) rd_chk("R1 reset acc", 2'(s), 32'h0, 32'h0);
    flag_chk("R1 reset flags", 4'b0000);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = req_of(v.code, v.exp_ovf);
      load(v.sel, v.pre_hi, v.pre_lo);
      issue(1'b1, v.sel, v.code, v.a, v.b);
      rd_chk({tag, " value"}, v.sel, v.exp_hi, v.exp_lo);
      flag_chk({tag, " flag"}, v.exp_ovf ? (4'b0001 << v.sel) : 4'b0000);
      clear_flags();
    end

    // R9: only the target changes
    load(2'd0, 32'h0, 32'h11);
    load(2'd1, 32'h0, 32'h22);
    load(2'd2, 32'h0, 32'h33);
    load(2'd3, 32'h0, 32'h44);
    issue(1'b1, 2'd2, 5'b00000, 32'h0001_0001, 32'h0001_0001);
    rd_chk("R9 target", 2'd2, 32'h0, 32'h35);
    rd_chk("R9 acc0 untouched", 2'd0, 32'h0, 32'h11);
    rd_chk("R9 acc1 untouched", 2'd1, 32'h0, 32'h22);
    rd_chk("R9 acc3 untouched", 2'd3, 32'h0, 32'h44);

    // R2: back-to-back accumulation
    issue(1'b1, 2'd0, 5'b00000, 32'h0003_0002, 32'h0005_0004);
    issue(1'b1, 2'd0, 5'b00000, 32'h0003_0002, 32'h0005_0004);
    rd_chk("R2 back-to-back", 2'd0, 32'h0, 32'h3F);

    // R12: no valid, or undefined code
    issue(1'b0, 2'd1, 5'b11000, 32'h8000_8000, 32'h8000_8000);
    rd_chk("R12 valid low value", 2'd1, 32'h0, 32'h22);
    flag_chk("R12 valid low flag", 4'b0000);
    issue(1'b1, 2'd1, 5'b11100, 32'h8000_8000, 32'h8000_8000);
    rd_chk("R12 bad code value", 2'd1, 32'h0, 32'h22);
    flag_chk("R12 bad code flag", 4'b0000);
    issue(1'b1, 2'd1, 5'b00010, 32'h0003_0002, 32'h0005_0004);
    rd_chk("R12 bad code 00010", 2'd1, 32'h0, 32'h22);

    // R11: write and op to the same accumulator
    wr_en_i = 1'b1; wr_acc_i = 2'd1; wr_hi_i = 32'hAAAA0000; wr_lo_i = 32'h5555;
    issue(1'b1, 2'd1, 5'b11000, 32'h8000_8000, 32'h8000_8000);
    wr_en_i = 1'b0;
    rd_chk("R11 write wins value", 2'd1, 32'hAAAA0000, 32'h5555);
    flag_chk("R11 write wins flag", 4'b0000);
    // R11: write and op to different accumulators
    wr_en_i = 1'b1; wr_acc_i = 2'd0; wr_hi_i = 32'h0; wr_lo_i = 32'h1000;
    issue(1'b1, 2'd3, 5'b00000, 32'h0001_0001, 32'h0002_0002);
    wr_en_i = 1'b0;
    rd_chk("R11 write other", 2'd0, 32'h0, 32'h1000);
    rd_chk("R11 op other", 2'd3, 32'h0, 32'h48);

    // R8: sticky flag, clear racing a new set
    issue(1'b1, 2'd3, 5'b11000, 32'h0000_8000, 32'h8000_0000);
    flag_chk("R8 flag set", 4'b1000);
    issue(1'b1, 2'd0, 5'b00000, 32'h0, 32'h0);
    flag_chk("R8 flag sticky", 4'b1000);
    ovf_clr_i = 1'b1;
    issue(1'b1, 2'd0, 5'b11000, 32'h0000_8000, 32'h8000_0000);
    ovf_clr_i = 1'b0;
    flag_chk("R8 clear with set", 4'b0001);
    clear_flags();
    flag_chk("R8 clear alone", 4'b0000);

    // R10: combinational read select, no clock
    rd_chk("R10 read acc3", 2'd3, 32'h0, 32'h80000047);
    rd_chk("R10 read acc0", 2'd0, 32'h0, 32'h80000FFF);
    rd_chk("R10 read acc1", 2'd1, 32'hAAAA0000, 32'h5555);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule